// File: doc/BRIEF.md
# Residue-Checked Integer Arithmetic Unit

This block is a one-stage integer arithmetic unit for unsigned operands. It adds, subtracts and multiplies, and beside the datapath that forms the result it runs an independent residue checker. The checker reduces both operands modulo a small check constant of the form 2^k-1. It applies the same operation to those reduced values and compares the outcome with the residue of the result that the datapath actually produced. A mismatch raises an error flag in the same cycle the result appears.

The checker taps the datapath only at its outputs: the low result word, plus the upper word that the wrap drops, which is the carry, the borrow or the high half of the product. The logic and timing of the arithmetic stay untouched, and one checker serves every opcode. A verification input XORs a mask into the result before it is registered, so a test can confirm that corruption reaches the flag. Equal residues only mean that no error was seen. A corruption that shifts the value by a multiple of the check constant passes unnoticed.

Top module: `resid_alu`

## Requirements
- R1: After an active-low reset, out_valid and out_err are 0 and out_result is 0.
- R2: Opcode 2'b00 returns in_a + in_b modulo 2^32. The carry out of the top bit is discarded.
- R3: Opcode 2'b01 returns in_a - in_b modulo 2^32. A borrow wraps the result, so 0 - 1 gives 32'hFFFFFFFF.
- R4: Opcode 2'b10 returns the low 32 bits of the full 64-bit product in_a * in_b.
- R5: Opcode 2'b11 is reserved and behaves exactly as opcode 2'b00.
- R6: The result appears on the clock edge after the one that samples in_valid high, with out_valid high for that cycle. In the cycle after a cycle with in_valid low, out_valid is 0.
- R7: When in_valid is low, out_result keeps its previous value and out_err is 0. out_err is never 1 while out_valid is 0.
- R8: out_result equals the true result XORed with in_fault, as sampled with the operation.
- R9: With in_fault zero, out_err is 0 for every opcode and operand pair, including cases that carry, borrow or overflow 32 bits.
- R10: With exactly one bit set in in_fault, out_err is 1 for every opcode.
- R11: The check constant is 3. out_err is 1 exactly when (out_result mod 3) differs from (true result mod 3). A multi-bit mask that shifts the value by a multiple of 3 goes undetected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Opcode: 00 add, 01 subtract, 10 multiply, 11 add |
| in_a | input | 32 | First operand, unsigned |
| in_b | input | 32 | Second operand, unsigned |
| in_fault | input | 32 | XOR mask applied to the result for fault injection |
| out_valid | output | 1 | Result and flag valid |
| out_result | output | 32 | Registered, possibly corrupted, result |
| out_err | output | 1 | Residue mismatch detected |

## Verification
The bench targets operands whose true value leaves the 32-bit word: an add that carries out, a subtract that borrows, and products whose high half is nonzero. A checker that ignored the dropped carry, borrow or upper product word would raise out_err on these clean operations. Every single-bit mask is applied under each opcode. A checker that read the result before the mask was applied would stay silent on these. Two-bit masks chosen to move the value by 3 and by 1 show that the flag follows the modulo-3 difference exactly, and that an undetectable corruption is not reported as one. Idle cycles confirm that out_valid drops while out_result holds its value, which catches a latency of the wrong length or an output that is not held.

// File: rtl/resid_alu_pkg.sv
package resid_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_MUL  = 2'b10,
      OP_ADD2 = 2'b11
   } alu_op_e;

   // residue of 2^w modulo (2^k - 1): equals 2^(w mod k)
   function automatic int unsigned wrap_residue(input int unsigned w, input int unsigned k);
      return 32'd1 << (w % k);
   endfunction

endpackage

// File: rtl/resid_fold.sv
module resid_fold #(
   parameter int unsigned IN_W = 32,
   parameter int unsigned K    = 2
) (
   input  logic [IN_W-1:0] val,
   output logic [K-1:0]    res
);
   localparam int unsigned NCH   = (IN_W + K - 1) / K;
   localparam int unsigned PAD_W = NCH * K;

   if (K < 2) begin : g_bad_k
      $error("resid_fold: K must be at least 2");
   end

   function automatic logic [K-1:0] eac_add(input logic [K-1:0] x, input logic [K-1:0] y);
      logic [K:0] s;
      s = {1'b0, x} + {1'b0, y};
      return s[K-1:0] + {{(K-1){1'b0}}, s[K]};
   endfunction

   logic [PAD_W-1:0]     padded;
   logic [NCH:0][K-1:0]  acc;

   assign padded = PAD_W'(val);
   assign acc[0] = '0;

   for (genvar i = 0; i < NCH; i++) begin : g_chunk
      assign acc[i+1] = eac_add(acc[i], padded[i*K +: K]);
   end

   // all-ones is the second encoding of zero
   assign res = (acc[NCH] == {K{1'b1}}) ? '0 : acc[NCH];
endmodule

// File: rtl/resid_alu_dp.sv
module resid_alu_dp
   import resid_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] lo,
   output logic [WIDTH-1:0] hi
);
   logic [WIDTH:0]     sum_w;
   logic [WIDTH:0]     dif_w;
   logic [2*WIDTH-1:0] prod_w;

   assign sum_w  = {1'b0, a} + {1'b0, b};
   assign dif_w  = {1'b0, a} - {1'b0, b};
   assign prod_w = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};

   always_comb begin
      unique case (op)
         OP_SUB: begin
            lo = dif_w[WIDTH-1:0];
            hi = WIDTH'(dif_w[WIDTH]);
         end
         OP_MUL: begin
            lo = prod_w[WIDTH-1:0];
            hi = prod_w[2*WIDTH-1:WIDTH];
         end
         default: begin
            lo = sum_w[WIDTH-1:0];
            hi = WIDTH'(sum_w[WIDTH]);
         end
      endcase
   end
endmodule

// File: rtl/resid_alu_chk.sv
module resid_alu_chk
   import resid_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned K     = 2
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] lo_obs,
   input  logic [WIDTH-1:0] hi_obs,
   output logic             mismatch
);
   localparam int unsigned PW = 2 * K;
   localparam logic [K-1:0] MODV     = {K{1'b1}};
   localparam logic [K-1:0] WRAP_RES = K'(wrap_residue(WIDTH, K));

   logic [K-1:0]         ra, rb, r_obs, r_exp;
   logic [2*WIDTH-1:0]   obs_full;
   logic [PW-1:0]        pre;

   resid_fold #(.IN_W(WIDTH), .K(K)) u_fold_a (.val(a), .res(ra));
   resid_fold #(.IN_W(WIDTH), .K(K)) u_fold_b (.val(b), .res(rb));

   // subtract: compare low word alone; borrow handled on the expected side
   assign obs_full = (op == OP_SUB) ? {{WIDTH{1'b0}}, lo_obs} : {hi_obs, lo_obs};
   resid_fold #(.IN_W(2*WIDTH), .K(K)) u_fold_obs (.val(obs_full), .res(r_obs));

   always_comb begin
      unique case (op)
         OP_SUB:  pre = PW'(ra) + PW'(MODV - rb) + (hi_obs[0] ? PW'(WRAP_RES) : '0);
         OP_MUL:  pre = PW'(ra) * PW'(rb);
         default: pre = PW'(ra) + PW'(rb);
      endcase
   end

   resid_fold #(.IN_W(PW), .K(K)) u_fold_exp (.val(pre), .res(r_exp));

   assign mismatch = (r_exp != r_obs);
endmodule

// File: rtl/resid_alu.sv
module resid_alu
   import resid_alu_pkg::*;
#(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned RES_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [WIDTH-1:0] in_fault,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_result,
   output logic             out_err
);
   if (RES_BITS < 2) begin : g_bad_res
      $error("resid_alu: RES_BITS must be at least 2");
   end
   if (WIDTH < RES_BITS) begin : g_bad_width
      $error("resid_alu: WIDTH must not be below RES_BITS");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] dp_lo, dp_hi, lo_inj;
   logic             mism;

   assign op = alu_op_e'(in_op);

   resid_alu_dp #(.WIDTH(WIDTH)) u_dp (
      .op(op), .a(in_a), .b(in_b), .lo(dp_lo), .hi(dp_hi)
   );

   assign lo_inj = dp_lo ^ in_fault;

   resid_alu_chk #(.WIDTH(WIDTH), .K(RES_BITS)) u_chk (
      .op(op), .a(in_a), .b(in_b), .lo_obs(lo_inj), .hi_obs(dp_hi), .mismatch(mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_err    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid & mism;
         if (in_valid) out_result <= lo_inj;
      end
   end
endmodule

// File: rtl/resid_alu_sva.sv
module resid_alu_sva #(
   parameter int unsigned WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_op,
   input logic [WIDTH-1:0] in_a,
   input logic [WIDTH-1:0] in_b,
   input logic [WIDTH-1:0] in_fault,
   input logic             out_valid,
   input logic [WIDTH-1:0] out_result,
   input logic             out_err
);
   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_err_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));
   assert_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fault == '0) |=> !out_err);
   assert_single_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $countones(in_fault) == 1) |=> out_err);
   assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b00 && in_fault == '0) |=> out_result == $past(in_a + in_b));
endmodule

bind resid_alu resid_alu_sva #(.WIDTH(WIDTH)) u_sva (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
   .in_a(in_a), .in_b(in_b), .in_fault(in_fault),
   .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
);

// File: tb/resid_alu_tb_top.sv
`timescale 1ns/1ps
module resid_alu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [31:0] in_a = '0, in_b = '0, in_fault = '0;
   logic        out_valid, out_err;
   logic [31:0] out_result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   resid_alu dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .in_fault(in_fault),
      .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
   );

   function automatic logic [31:0] ref_res(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p;
      case (op)
         2'b01:   return a - b;
         2'b10:   begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
         default: return a + b;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one op, sample after the capturing edge, return to idle
   task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] f, output logic [31:0] res, output logic err,
                         output logic vld);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_fault = f;
      @(negedge clk);
      res = out_result; err = out_err; vld = out_valid;
      in_valid = 1'b0; in_fault = '0;
   endtask

   task automatic op_check(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
      logic [31:0] r, e; logic er, v;
      e = ref_res(op, a, b);
      run_op(op, a, b, 32'd0, r, er, v);
      check(r == e, req, r, e);
      check(er == 1'b0, "R9", {31'd0, er}, 32'd0);
      check(v == 1'b1, "R6", {31'd0, v}, 32'd1);
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
      check(out_err == 1'b0, "R1", {31'd0, out_err}, 32'd0);
      check(out_result == 32'd0, "R1", out_result, 32'd0);
   endtask

   task automatic t_add;
      op_check(2'b00, 32'd7, 32'd9, "R2");
      op_check(2'b00, 32'hFFFF_FFFF, 32'd1, "R2");
      op_check(2'b00, 32'h8000_0001, 32'h8000_0003, "R2");
   endtask

   task automatic t_sub;
      op_check(2'b01, 32'd100, 32'd58, "R3");
      op_check(2'b01, 32'd0, 32'd1, "R3");
      op_check(2'b01, 32'd5, 32'hFFFF_FFFE, "R3");
   endtask

   task automatic t_mul;
      op_check(2'b10, 32'd12345, 32'd678, "R4");
      op_check(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
      op_check(2'b10, 32'h0001_0000, 32'h0001_0000, "R4");
      op_check(2'b10, 32'hDEAD_BEEF, 32'h1234_5679, "R4");
   endtask

   task automatic t_reserved;
      op_check(2'b11, 32'hFFFF_FFF0, 32'h0000_0020, "R5");
      op_check(2'b11, 32'd3, 32'd4, "R5");
   endtask

   task automatic t_idle_hold;
      logic [31:0] r, e; logic er, v;
      e = ref_res(2'b10, 32'd11, 32'd13);
      run_op(2'b10, 32'd11, 32'd13, 32'd0, r, er, v);
      in_a = 32'h5555_5555; in_b = 32'd2; in_fault = 32'hFFFF_FFFF;
      @(negedge clk);
      check(out_valid == 1'b0, "R6", {31'd0, out_valid}, 32'd0);
      check(out_result == e, "R7", out_result, e);
      check(out_err == 1'b0, "R7", {31'd0, out_err}, 32'd0);
      in_fault = '0;
   endtask

   task automatic t_single_flip;
      logic [31:0] r, e; logic er, v;
      for (int op = 0; op < 3; op++) begin
         for (int bt = 0; bt < 32; bt++) begin
            e = ref_res(2'(op), 32'hA5C3_0F1E + 32'(bt), 32'h0137_9BDF);
            run_op(2'(op), 32'hA5C3_0F1E + 32'(bt), 32'h0137_9BDF, 32'd1 << bt, r, er, v);
            check(er == 1'b1, "R10", {31'd0, er}, 32'd1);
            check(r == (e ^ (32'd1 << bt)), "R8", r, e ^ (32'd1 << bt));
         end
      end
   endtask

   task automatic t_multi_flip;
      logic [31:0] r, e; logic er, v, ex;
      // 4 -> 7 moves by 3: undetectable; 5 -> 6 moves by 1: detected
      run_op(2'b00, 32'd4, 32'd0, 32'd3, r, er, v);
      check(er == 1'b0 && r == 32'd7, "R11", {31'd0, er}, 32'd0);
      run_op(2'b00, 32'd5, 32'd0, 32'd3, r, er, v);
      check(er == 1'b1 && r == 32'd6, "R11", {31'd0, er}, 32'd1);
      for (int k = 0; k < 8; k++) begin
         e = ref_res(2'b10, 32'h0F0F_1234 + 32'(k * 77), 32'd991);
         run_op(2'b10, 32'h0F0F_1234 + 32'(k * 77), 32'd991, 32'h0000_0C00 | 32'(k), r, er, v);
         ex = ((r % 3) != (e % 3));
         check(er == ex, "R11", {31'd0, er}, {31'd0, ex});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_add;
      t_sub;
      t_mul;
      t_reserved;
      t_idle_hold;
      t_single_flip;
      t_multi_flip;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule